// File: doc/BRIEF.md
# Update-Protocol Line Coherence Controller

This block keeps the coherence state of every line in one write-back cache. It uses a write-update scheme: a write to a line that other caches also hold is broadcast as an update, so those copies are refreshed rather than killed. A frame that has been filled never becomes invalid. It changes state only by processor activity, by snooped traffic, or by being replaced with a new line. Each filled frame is in one of four states: Exclusive (clean, sole copy), Shared-clean, Shared-modified (possibly dirty, this cache owns it), and Modified (dirty, sole copy). The 2-bit encoding is 0, 1, 2 and 3 in that order.

The tag array is direct-mapped. The low index bits of the line address pick a frame and the remaining bits form the tag. A processor request is resolved in the cycle it is presented. The copies-exist line `copies_i` is sampled in that same cycle. The result and the bus commands it causes appear on registered outputs one cycle later.

Snooped commands on `snp_cmd_i` use the encoding 0 none, 1 bus read, 2 bus update, 3 flush. When a snooped read or update hits a held line, the block drives `copies_o` in the same cycle. Data payloads are not modelled: a flush, a write-back and a data refresh are single-cycle strobes with an address.

Top module: `dragon_coherence_ctl`

## Requirements
- R1: After reset every registered output is 0, and the first access to any frame is a miss.
- R2: A read miss raises `bus_rd_o` one cycle later. The line is filled as Shared-clean (1) if `copies_i` was high, and as Exclusive (0) otherwise. No update is issued.
- R3: A read hit gives `cpu_hit_o`=1, issues no bus read, update or write-back, and reports the unchanged state.
- R4: A write hit on an Exclusive line moves it to Modified (3) with no bus traffic.
- R5: A write hit on a Shared-clean or Shared-modified line raises `bus_upd_o`. The line ends in Shared-modified (2) if `copies_i` was high, and in Modified (3) otherwise.
- R6: A write miss raises `bus_rd_o`. If `copies_i` was high it also raises `bus_upd_o` and the line enters Shared-modified; otherwise it enters Modified with no update.
- R7: A snooped bus read that hits drives `copies_o` in the same cycle. On a Modified or Shared-modified line it raises `flush_o` one cycle later, and Modified becomes Shared-modified. Exclusive becomes Shared-clean. Shared-clean is unchanged and gives no flush.
- R8: A snooped bus update that hits drives `copies_o` and raises `data_upd_o` one cycle later. It moves Shared-modified to Shared-clean. It is never observed on an Exclusive or Modified line.
- R9: A snooped flush, or any snoop that misses the tag array, leaves the state unchanged, drives no `copies_o` and produces no output strobe.
- R10: A miss that replaces a Modified or Shared-modified line raises `wb_o`, with `victim_addr_o` set to the evicted line's address. Replacing a clean line raises no write-back.
- R11: When a snoop and a processor request hit the same frame in one cycle, the snoop takes effect first, and the processor request acts on the state the snoop leaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_req_i | input | 1 | Processor request valid |
| cpu_we_i | input | 1 | Request is a write |
| cpu_addr_i | input | ADDR_W | Request line address |
| snp_cmd_i | input | 2 | Snooped command: 0 none, 1 read, 2 update, 3 flush |
| snp_addr_i | input | ADDR_W | Snooped line address |
| copies_i | input | 1 | Copies-exist line, sampled with a processor request |
| copies_o | output | 1 | This cache holds the snooped line |
| cpu_done_o | output | 1 | Processor request resolved |
| cpu_hit_o | output | 1 | Request hit the tag array |
| cpu_state_o | output | 2 | Line state after the request |
| bus_rd_o | output | 1 | Issue bus read |
| bus_upd_o | output | 1 | Issue bus update |
| req_addr_o | output | ADDR_W | Address of the bus read or update |
| wb_o | output | 1 | Write back an evicted dirty line |
| victim_addr_o | output | ADDR_W | Address of the evicted line |
| flush_o | output | 1 | Supply the line to a snooped read |
| flush_addr_o | output | ADDR_W | Address of the flushed line |
| data_upd_o | output | 1 | Local copy refreshed by a snooped update |

## Verification
A snooped command and a processor request can hit the same frame in the same cycle, and the snoop must be applied first. The bench drives a snooped update together with a read of a Shared-modified line, and expects a hit reporting Shared-clean plus a data refresh. It also drives a snooped read together with a write to a Modified line, and expects a flush and a bus update together, with the line left Shared-modified. Both combined outcomes are compared field by field against queued expectations.

// File: rtl/dragon_pkg.sv
package dragon_pkg;
  typedef enum logic [1:0] {
    ST_EXCL = 2'd0,
    ST_SCLN = 2'd1,
    ST_SMOD = 2'd2,
    ST_MOD  = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    SN_NONE  = 2'd0,
    SN_RD    = 2'd1,
    SN_UPD   = 2'd2,
    SN_FLUSH = 2'd3
  } snp_cmd_t;
endpackage

// File: rtl/dragon_tag_store.sv
module dragon_tag_store
  import dragon_pkg::*;
#(
  parameter int SETS  = 8,
  parameter int TAG_W = 13,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] c_idx_i,
  output logic             c_valid_o,
  output logic [TAG_W-1:0] c_tag_o,
  output line_st_t         c_st_o,
  input  logic [IDX_W-1:0] s_idx_i,
  output logic             s_valid_o,
  output logic [TAG_W-1:0] s_tag_o,
  output line_st_t         s_st_o,
  input  logic             a_wr_i,
  input  logic [TAG_W-1:0] a_tag_i,
  input  line_st_t         a_st_i,
  input  logic             b_wr_i,
  input  line_st_t         b_st_i
);
  logic [SETS-1:0]  valid_q;
  logic [TAG_W-1:0] tag_q [SETS];
  line_st_t         st_q  [SETS];

  assign c_valid_o = valid_q[c_idx_i];
  assign c_tag_o   = tag_q[c_idx_i];
  assign c_st_o    = st_q[c_idx_i];
  assign s_valid_o = valid_q[s_idx_i];
  assign s_tag_o   = tag_q[s_idx_i];
  assign s_st_o    = st_q[s_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int i = 0; i < SETS; i++) begin
        tag_q[i] <= '0;
        st_q[i]  <= ST_EXCL;
      end
    end else begin
      if (b_wr_i) st_q[s_idx_i] <= b_st_i;
      // processor write wins; it already folds in the snoop result
      if (a_wr_i) begin
        valid_q[c_idx_i] <= 1'b1;
        tag_q[c_idx_i]   <= a_tag_i;
        st_q[c_idx_i]    <= a_st_i;
      end
    end
  end
endmodule

// File: rtl/dragon_snoop_ctl.sv
module dragon_snoop_ctl
  import dragon_pkg::*;
(
  input  snp_cmd_t cmd_i,
  input  logic     hit_i,
  input  line_st_t st_i,
  output line_st_t nxt_st_o,
  output logic     wr_o,
  output logic     copies_o,
  output logic     flush_o,
  output logic     dupd_o
);
  always_comb begin
    nxt_st_o = st_i;
    wr_o     = 1'b0;
    copies_o = 1'b0;
    flush_o  = 1'b0;
    dupd_o   = 1'b0;
    if (hit_i) begin
      unique case (cmd_i)
        SN_RD: begin
          copies_o = 1'b1;
          wr_o     = 1'b1;
          flush_o  = (st_i == ST_MOD) || (st_i == ST_SMOD);
          if (st_i == ST_EXCL)     nxt_st_o = ST_SCLN;
          else if (st_i == ST_MOD) nxt_st_o = ST_SMOD;
        end
        SN_UPD: begin
          copies_o = 1'b1;
          dupd_o   = 1'b1;
          wr_o     = 1'b1;
          if (st_i == ST_SMOD) nxt_st_o = ST_SCLN;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dragon_cpu_ctl.sv
module dragon_cpu_ctl
  import dragon_pkg::*;
(
  input  logic     req_i,
  input  logic     we_i,
  input  logic     hit_i,
  input  line_st_t st_i,
  input  logic     vic_valid_i,
  input  logic     copies_i,
  output line_st_t nxt_st_o,
  output logic     wr_o,
  output logic     rd_o,
  output logic     upd_o,
  output logic     wb_o
);
  always_comb begin
    nxt_st_o = st_i;
    wr_o     = 1'b0;
    rd_o     = 1'b0;
    upd_o    = 1'b0;
    wb_o     = 1'b0;
    if (req_i) begin
      wr_o = 1'b1;
      if (hit_i) begin
        if (we_i) begin
          if (st_i == ST_SCLN || st_i == ST_SMOD) begin
            upd_o    = 1'b1;
            nxt_st_o = copies_i ? ST_SMOD : ST_MOD;
          end else begin
            nxt_st_o = ST_MOD;
          end
        end
      end else begin
        rd_o = 1'b1;
        wb_o = vic_valid_i && (st_i == ST_MOD || st_i == ST_SMOD);
        if (we_i) begin
          upd_o    = copies_i;
          nxt_st_o = copies_i ? ST_SMOD : ST_MOD;
        end else begin
          nxt_st_o = copies_i ? ST_SCLN : ST_EXCL;
        end
      end
    end
  end
endmodule

// File: rtl/dragon_coherence_ctl.sv
module dragon_coherence_ctl
  import dragon_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SETS   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [1:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  input  logic              copies_i,
  output logic              copies_o,
  output logic              cpu_done_o,
  output logic              cpu_hit_o,
  output logic [1:0]        cpu_state_o,
  output logic              bus_rd_o,
  output logic              bus_upd_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic              wb_o,
  output logic [ADDR_W-1:0] victim_addr_o,
  output logic              flush_o,
  output logic [ADDR_W-1:0] flush_addr_o,
  output logic              data_upd_o
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0] c_idx, s_idx;
  logic [TAG_W-1:0] c_tag_in, s_tag_in, c_tag, s_tag;
  logic             c_valid, s_valid;
  line_st_t         c_st_raw, s_st, snp_nxt, cpu_nxt, c_st;
  logic             snp_hit, s_wr, s_copies, s_flush, s_dupd;
  logic             c_hit, c_wr, c_rd, c_upd, c_wb;
  snp_cmd_t         snp_cmd;

  assign c_idx    = cpu_addr_i[IDX_W-1:0];
  assign c_tag_in = cpu_addr_i[ADDR_W-1:IDX_W];
  assign s_idx    = snp_addr_i[IDX_W-1:0];
  assign s_tag_in = snp_addr_i[ADDR_W-1:IDX_W];
  assign snp_cmd  = snp_cmd_t'(snp_cmd_i);

  dragon_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) i_tags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .c_idx_i  (c_idx),
    .c_valid_o(c_valid),
    .c_tag_o  (c_tag),
    .c_st_o   (c_st_raw),
    .s_idx_i  (s_idx),
    .s_valid_o(s_valid),
    .s_tag_o  (s_tag),
    .s_st_o   (s_st),
    .a_wr_i   (c_wr),
    .a_tag_i  (c_tag_in),
    .a_st_i   (cpu_nxt),
    .b_wr_i   (s_wr),
    .b_st_i   (snp_nxt)
  );

  assign snp_hit = s_valid && (s_tag == s_tag_in);

  dragon_snoop_ctl i_snoop (
    .cmd_i   (snp_cmd),
    .hit_i   (snp_hit),
    .st_i    (s_st),
    .nxt_st_o(snp_nxt),
    .wr_o    (s_wr),
    .copies_o(s_copies),
    .flush_o (s_flush),
    .dupd_o  (s_dupd)
  );

  // snoop result is seen first by a request to the same frame
  assign c_st  = (s_wr && (s_idx == c_idx)) ? snp_nxt : c_st_raw;
  assign c_hit = c_valid && (c_tag == c_tag_in);

  dragon_cpu_ctl i_cpu (
    .req_i      (cpu_req_i),
    .we_i       (cpu_we_i),
    .hit_i      (c_hit),
    .st_i       (c_st),
    .vic_valid_i(c_valid),
    .copies_i   (copies_i),
    .nxt_st_o   (cpu_nxt),
    .wr_o       (c_wr),
    .rd_o       (c_rd),
    .upd_o      (c_upd),
    .wb_o       (c_wb)
  );

  assign copies_o = s_copies;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_done_o    <= 1'b0;
      cpu_hit_o     <= 1'b0;
      cpu_state_o   <= '0;
      bus_rd_o      <= 1'b0;
      bus_upd_o     <= 1'b0;
      req_addr_o    <= '0;
      wb_o          <= 1'b0;
      victim_addr_o <= '0;
      flush_o       <= 1'b0;
      flush_addr_o  <= '0;
      data_upd_o    <= 1'b0;
    end else begin
      cpu_done_o    <= cpu_req_i;
      cpu_hit_o     <= cpu_req_i && c_hit;
      cpu_state_o   <= cpu_req_i ? cpu_nxt : '0;
      bus_rd_o      <= c_rd;
      bus_upd_o     <= c_upd;
      req_addr_o    <= cpu_addr_i;
      wb_o          <= c_wb;
      victim_addr_o <= {c_tag, c_idx};
      flush_o       <= s_flush;
      flush_addr_o  <= snp_addr_i;
      data_upd_o    <= s_dupd;
    end
  end
endmodule

// File: rtl/dragon_coherence_chk.sv
module dragon_coherence_chk
  import dragon_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] snp_cmd_i,
  input logic       copies_i,
  input logic       copies_o,
  input logic       cpu_done_o,
  input logic       cpu_hit_o,
  input logic [1:0] cpu_state_o,
  input logic       bus_rd_o,
  input logic       bus_upd_o,
  input logic       wb_o,
  input logic       flush_o,
  input logic       snp_hit,
  input line_st_t   s_st
);
  assert_rd_on_miss_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_o |-> cpu_done_o && !cpu_hit_o);

  assert_hit_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_hit_o |-> !bus_rd_o && !wb_o);

  // R5 and R6: update outcome follows the sampled copies-exist line
  assert_upd_state_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_upd_o |-> cpu_state_o == ($past(copies_i) ? 2'd2 : 2'd3));

  assert_flush_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> $past(snp_cmd_i) == 2'd1);

  assert_copies_cmd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    copies_o |-> (snp_cmd_i == 2'd1 || snp_cmd_i == 2'd2));

  assert_upd_not_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_cmd_i == 2'd2 && snp_hit) |-> (s_st == ST_SCLN || s_st == ST_SMOD));

  assert_wb_on_miss_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_o |-> cpu_done_o && !cpu_hit_o && bus_rd_o);
endmodule

bind dragon_coherence_ctl dragon_coherence_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .snp_cmd_i  (snp_cmd_i),
  .copies_i   (copies_i),
  .copies_o   (copies_o),
  .cpu_done_o (cpu_done_o),
  .cpu_hit_o  (cpu_hit_o),
  .cpu_state_o(cpu_state_o),
  .bus_rd_o   (bus_rd_o),
  .bus_upd_o  (bus_upd_o),
  .wb_o       (wb_o),
  .flush_o    (flush_o),
  .snp_hit    (snp_hit),
  .s_st       (s_st)
);

// File: tb/test_dragon_coherence_ctl.sv
module test_dragon_coherence_ctl;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cpu_req_i = 1'b0, cpu_we_i = 1'b0, copies_i = 1'b0;
  logic [AW-1:0] cpu_addr_i = '0, snp_addr_i = '0;
  logic [1:0]    snp_cmd_i = '0;
  logic          copies_o, cpu_done_o, cpu_hit_o, bus_rd_o, bus_upd_o;
  logic          wb_o, flush_o, data_upd_o;
  logic [1:0]    cpu_state_o;
  logic [AW-1:0] req_addr_o, victim_addr_o, flush_addr_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  dragon_coherence_ctl i_dragon_coherence_ctl (
    .clk_i(clk), .rst_ni(rst_ni), .cpu_req_i(cpu_req_i), .cpu_we_i(cpu_we_i),
    .cpu_addr_i(cpu_addr_i), .snp_cmd_i(snp_cmd_i), .snp_addr_i(snp_addr_i),
    .copies_i(copies_i), .copies_o(copies_o), .cpu_done_o(cpu_done_o),
    .cpu_hit_o(cpu_hit_o), .cpu_state_o(cpu_state_o), .bus_rd_o(bus_rd_o),
    .bus_upd_o(bus_upd_o), .req_addr_o(req_addr_o), .wb_o(wb_o),
    .victim_addr_o(victim_addr_o), .flush_o(flush_o), .flush_addr_o(flush_addr_o),
    .data_upd_o(data_upd_o)
  );

  typedef struct {
    logic [8:0]    v;  // done,hit,st[1:0],rd,upd,wb,flush,dupd
    logic [AW-1:0] vaddr;
    string         tg;
  } exp_t;

  exp_t q[$];

  function automatic exp_t ex(logic d, logic h, logic [1:0] s, logic r, logic u,
                              logic w, logic f, logic du, logic [AW-1:0] va, string tg);
    exp_t e;
    e.v = {d, h, s, r, u, w, f, du};
    e.vaddr = va;
    e.tg = tg;
    return e;
  endfunction

  task automatic step(logic req, logic we, logic [AW-1:0] a, logic cp,
                      logic [1:0] sc, logic [AW-1:0] sa, logic exp_cp, exp_t e);
    @(negedge clk);
    cpu_req_i = req; cpu_we_i = we; cpu_addr_i = a; copies_i = cp;
    snp_cmd_i = sc; snp_addr_i = sa;
    #1;
    checks++;
    if (copies_o !== exp_cp) begin
      fails++;
      $display("FAIL %s copies_o actual=%b expected=%b", e.tg, copies_o, exp_cp);
    end
    q.push_back(e);
  endtask

  task automatic idle();
    step(1'b0, 1'b0, '0, 1'b0, 2'd0, '0, 1'b0, ex(0,0,0,0,0,0,0,0,'0,"idle"));
  endtask

  // monitor: compare registered outputs right after each edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      logic [8:0] act;
      e = q.pop_front();
      act = {cpu_done_o, cpu_hit_o, cpu_state_o, bus_rd_o, bus_upd_o, wb_o,
             flush_o, data_upd_o};
      checks++;
      if (act !== e.v || (e.v[2] && victim_addr_o !== e.vaddr)) begin
        fails++;
        $display("FAIL %s outputs actual=%b vaddr=%h expected=%b vaddr=%h",
                 e.tg, act, victim_addr_o, e.v, e.vaddr);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    checks++;
    if ({cpu_done_o, cpu_hit_o, cpu_state_o, bus_rd_o, bus_upd_o, wb_o, flush_o,
         data_upd_o, copies_o} !== '0) begin
      fails++;
      $display("FAIL R1 reset outputs actual nonzero expected 0");
    end
    // R1 R2: first read misses, alone -> Exclusive
    step(1,0,16'h0010,0,0,0,0, ex(1,0,0,1,0,0,0,0,'0,"R2 read miss excl"));
    // R3: read hit quiet
    step(1,0,16'h0010,1,0,0,0, ex(1,1,0,0,0,0,0,0,'0,"R3 read hit"));
    // R4: write Exclusive -> Modified silently
    step(1,1,16'h0010,1,0,0,0, ex(1,1,3,0,0,0,0,0,'0,"R4 write excl"));
    // R7: snooped read on Modified -> flush, becomes SM
    step(0,0,0,0,1,16'h0010,1, ex(0,0,0,0,0,0,1,0,'0,"R7 snoop rd mod"));
    step(1,0,16'h0010,0,0,0,0, ex(1,1,2,0,0,0,0,0,'0,"R7 state SM"));
    // R8: snooped update on SM -> SC with refresh
    step(0,0,0,0,2,16'h0010,1, ex(0,0,0,0,0,0,0,1,'0,"R8 snoop upd"));
    step(1,0,16'h0010,0,0,0,0, ex(1,1,1,0,0,0,0,0,'0,"R8 state SC"));
    // R5: write hit shared
    step(1,1,16'h0010,1,0,0,0, ex(1,1,2,0,1,0,0,0,'0,"R5 write SC copies"));
    step(1,1,16'h0010,0,0,0,0, ex(1,1,3,0,1,0,0,0,'0,"R5 write SM alone"));
    // R9: snooped flush and snoop miss have no effect
    step(0,0,0,0,3,16'h0010,0, ex(0,0,0,0,0,0,0,0,'0,"R9 snoop flush"));
    step(0,0,0,0,1,16'h0020,0, ex(0,0,0,0,0,0,0,0,'0,"R9 snoop miss"));
    step(1,0,16'h0010,0,0,0,0, ex(1,1,3,0,0,0,0,0,'0,"R9 state kept M"));
    // R2 with copies -> SC; R7 snoop read on SC: no flush
    step(1,0,16'h0001,1,0,0,0, ex(1,0,1,1,0,0,0,0,'0,"R2 read miss shared"));
    step(0,0,0,0,1,16'h0001,1, ex(0,0,0,0,0,0,0,0,'0,"R7 snoop rd SC"));
    step(1,0,16'h0001,0,0,0,0, ex(1,1,1,0,0,0,0,0,'0,"R7 SC kept"));
    // R6: write misses
    step(1,1,16'h0002,1,0,0,0, ex(1,0,2,1,1,0,0,0,'0,"R6 write miss copies"));
    step(1,1,16'h0003,0,0,0,0, ex(1,0,3,1,0,0,0,0,'0,"R6 write miss alone"));
    // R10: eviction of dirty and clean lines
    step(1,0,16'h0018,0,0,0,0, ex(1,0,0,1,0,1,0,0,16'h0010,"R10 dirty evict"));
    step(1,0,16'h0009,0,0,0,0, ex(1,0,0,1,0,0,0,0,'0,"R10 clean evict"));
    // R11: same-frame snoop and request in one cycle
    step(1,0,16'h0002,0,2,16'h0002,1, ex(1,1,1,0,0,0,0,1,'0,"R11 upd+read"));
    step(1,1,16'h0003,1,1,16'h0003,1, ex(1,1,2,0,1,0,1,0,'0,"R11 rd+write"));
    idle();
    idle();
    wait (q.size() == 0);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule